// File: doc/BRIEF.md
# Tester Vector Word Assembler

This block sits between a deep pattern memory and the pin formatters of one group of tester channels. The memory delivers 72-bit words faster than the vector rate. The block gathers the words that make up one test vector into a shadow buffer. When the vector-rate strobe arrives, it decodes the buffer into per-channel drive data, drive enable and compare enable, and moves the result into the output register. The group runs in one of two modes. In bidirectional mode each of 96 channels takes a 3-bit code and a vector spans four words. In dedicated mode each of 64 one-way channels takes a 2-bit code and a vector spans two words. In both modes the word count is rounded up, and the bits left over after the last channel are padding.

The collector is a three-state machine. EMPTY waits for the first word of a vector. FILL counts the words that follow. FULL holds a complete vector until the strobe consumes it. The transitions are:
- start (EMPTY to FILL) on the first word.
- complete (FILL to FULL) on the last word the mode needs.
- drain (FULL to EMPTY) on a strobe with no word.
- restart (FULL to FILL) on a strobe that carries a word.
- flush (any state to EMPTY) when a mode change is accepted.

A strobe outside FULL is an underrun. The block reports it, keeps the last vector on the outputs and leaves the partial fill intact.

Top module: `vec_word_asm`

## Requirements
- R1: While reset is asserted, every channel output, the vector-valid pulse and the underrun pulse are 0, and the active mode is bidirectional (encoding 0).
- R2: In bidirectional mode (mode 0), four words form a vector. The first word received takes bits [71:0], the next takes [143:72], and so on. Channel n reads bits [3n+2:3n] as {compare enable, drive enable, drive data}.
- R3: In dedicated mode (mode 1), two words form a vector. Channel n (n < 64) reads bits [2n+1:2n] as {mask, data}. Its drive data equals the data bit, its compare enable is the inverse of mask, and its drive enable is 0. Channels 64 to 95 output all zeros.
- R4: In dedicated mode, bits [143:128] of the assembled vector are padding and change no output.
- R5: A strobe seen with a complete vector gives a one-cycle vector-valid pulse in the next cycle, and the new channel outputs appear in that same cycle.
- R6: A strobe seen with an incomplete vector gives a one-cycle underrun pulse in the next cycle, with no vector-valid pulse. The outputs hold the previous vector, and the words already collected are kept toward the same vector.
- R7: A word that arrives while a complete vector waits for its strobe is discarded.
- R8: A word that arrives in the same cycle as the consuming strobe becomes the first word of the next vector.
- R9: A change of the mode select is accepted only in a cycle with no word valid. Acceptance discards any partially collected vector.
- R10: The active-mode output shows the accepted mode from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Requested group mode, 0 bidirectional, 1 dedicated |
| wvalid_i | input | 1 | Pattern word valid |
| wdata_i | input | 72 | Pattern word |
| vstrobe_i | input | 1 | Vector-rate strobe |
| drv_data_o | output | 96 | Per-channel drive data |
| drv_en_o | output | 96 | Per-channel drive enable |
| cmp_en_o | output | 96 | Per-channel compare enable |
| vvalid_o | output | 1 | One-cycle pulse when a new vector is presented |
| underrun_o | output | 1 | One-cycle pulse when a strobe found no complete vector |
| active_mode_o | output | 1 | Mode currently applied to the group |

## Verification
A wrong word count or slot index in the collector shows up one cycle after the next strobe: either channel codes land on the wrong channels, or vector-valid is replaced by underrun. The scoreboard catches either on the first affected vector. A stale FULL state or a missed flush after a mode change shows up as a vector built from words left over from before the change, on the first strobe that follows. Decode errors such as a wrong field order, a driver left enabled in dedicated mode, or padding bits leaking into channels appear on the very pulse that presents the vector.

// File: rtl/vwa_pkg.sv
package vwa_pkg;

    typedef enum logic {
        MODE_BIDIR = 1'b0,
        MODE_DED   = 1'b1
    } grp_mode_t;

    typedef enum logic [1:0] {
        COL_EMPTY = 2'd0,
        COL_FILL  = 2'd1,
        COL_FULL  = 2'd2
    } col_state_t;

endpackage

// File: rtl/vwa_collect.sv
module vwa_collect
    import vwa_pkg::*;
#(
    parameter int WORD_W   = 72,
    parameter int SHADOW_W = 288,
    parameter int CNT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_vld,
    input  logic [WORD_W-1:0]   word,
    input  logic [CNT_W-1:0]    need,
    input  logic                take,
    input  logic                flush,
    output logic                full_o,
    output logic [SHADOW_W-1:0] shadow_o
);

    col_state_t          st_q, st_n;
    logic [CNT_W-1:0]    cnt_q, cnt_n;
    logic [SHADOW_W-1:0] shadow_q, shadow_n;
    logic                wr_en, clr;
    logic [CNT_W-1:0]    wr_slot;

    // next state and write control
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        wr_en   = 1'b0;
        clr     = 1'b0;
        wr_slot = cnt_q;
        if (flush) begin
            st_n  = COL_EMPTY;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                COL_EMPTY: begin
                    if (word_vld) begin
                        wr_en   = 1'b1;
                        clr     = 1'b1;
                        wr_slot = '0;
                        if (need == CNT_W'(1)) begin
                            st_n  = COL_FULL;
                            cnt_n = '0;
                        end else begin
                            st_n  = COL_FILL;
                            cnt_n = CNT_W'(1);
                        end
                    end
                end
                COL_FILL: begin
                    if (word_vld) begin
                        wr_en = 1'b1;
                        if (CNT_W'(cnt_q + 1'b1) == need) begin
                            st_n  = COL_FULL;
                            cnt_n = '0;
                        end else begin
                            cnt_n = CNT_W'(cnt_q + 1'b1);
                        end
                    end
                end
                COL_FULL: begin
                    if (take) begin
                        if (word_vld) begin
                            wr_en   = 1'b1;
                            clr     = 1'b1;
                            wr_slot = '0;
                            st_n    = COL_FILL;
                            cnt_n   = CNT_W'(1);
                        end else begin
                            st_n  = COL_EMPTY;
                            cnt_n = '0;
                        end
                    end
                end
                default: begin
                    st_n  = COL_EMPTY;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // shadow buffer update, zero fill on the first word of a vector
    always_comb begin
        shadow_n = shadow_q;
        if (wr_en) begin
            if (clr) begin
                shadow_n = '0;
            end
            shadow_n[int'(wr_slot) * WORD_W +: WORD_W] = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= COL_EMPTY;
            cnt_q    <= '0;
            shadow_q <= '0;
        end else begin
            st_q     <= st_n;
            cnt_q    <= cnt_n;
            shadow_q <= shadow_n;
        end
    end

    always_comb begin
        full_o   = (st_q == COL_FULL);
        shadow_o = shadow_q;
    end

endmodule

// File: rtl/vwa_decode.sv
module vwa_decode
    import vwa_pkg::*;
#(
    parameter int SHADOW_W = 288,
    parameter int CH       = 96,
    parameter int DED_CH   = 64
) (
    input  grp_mode_t           mode,
    input  logic [SHADOW_W-1:0] shadow,
    output logic [CH-1:0]       data_o,
    output logic [CH-1:0]       den_o,
    output logic [CH-1:0]       cen_o
);

    logic bidir;
    assign bidir = (mode == MODE_BIDIR);

    for (genvar n = 0; n < CH; n++) begin : g_ch
        if (n < DED_CH) begin : g_both
            assign data_o[n] = bidir ? shadow[3*n]     : shadow[2*n];
            assign den_o[n]  = bidir ? shadow[3*n + 1] : 1'b0;
            assign cen_o[n]  = bidir ? shadow[3*n + 2] : ~shadow[2*n + 1];
        end else begin : g_bidir_only
            assign data_o[n] = bidir & shadow[3*n];
            assign den_o[n]  = bidir & shadow[3*n + 1];
            assign cen_o[n]  = bidir & shadow[3*n + 2];
        end
    end

endmodule

// File: rtl/vec_word_asm.sv
module vec_word_asm
    import vwa_pkg::*;
#(
    parameter int WORD_W   = 72,
    parameter int BIDIR_CH = 96,
    parameter int DED_CH   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_sel_i,
    input  logic                wvalid_i,
    input  logic [WORD_W-1:0]   wdata_i,
    input  logic                vstrobe_i,
    output logic [BIDIR_CH-1:0] drv_data_o,
    output logic [BIDIR_CH-1:0] drv_en_o,
    output logic [BIDIR_CH-1:0] cmp_en_o,
    output logic                vvalid_o,
    output logic                underrun_o,
    output logic                active_mode_o
);

    localparam int BIDIR_WORDS = (BIDIR_CH * 3 + WORD_W - 1) / WORD_W;
    localparam int DED_WORDS   = (DED_CH * 2 + WORD_W - 1) / WORD_W;
    localparam int MAX_WORDS   = (BIDIR_WORDS > DED_WORDS) ? BIDIR_WORDS : DED_WORDS;
    localparam int SHADOW_W    = MAX_WORDS * WORD_W;
    localparam int CNT_W       = $clog2(MAX_WORDS + 1);

    grp_mode_t           mode_q;
    logic                mode_acc, full, swap;
    logic [CNT_W-1:0]    need;
    logic [SHADOW_W-1:0] shadow;
    logic [BIDIR_CH-1:0] dec_data, dec_den, dec_cen;

    assign mode_acc = !wvalid_i && (grp_mode_t'(mode_sel_i) != mode_q);
    assign need     = (mode_q == MODE_BIDIR) ? CNT_W'(BIDIR_WORDS) : CNT_W'(DED_WORDS);
    assign swap     = vstrobe_i && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_BIDIR;
        end else if (mode_acc) begin
            mode_q <= grp_mode_t'(mode_sel_i);
        end
    end

    vwa_collect #(
        .WORD_W  (WORD_W),
        .SHADOW_W(SHADOW_W),
        .CNT_W   (CNT_W)
    ) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_vld(wvalid_i),
        .word    (wdata_i),
        .need    (need),
        .take    (vstrobe_i),
        .flush   (mode_acc),
        .full_o  (full),
        .shadow_o(shadow)
    );

    vwa_decode #(
        .SHADOW_W(SHADOW_W),
        .CH      (BIDIR_CH),
        .DED_CH  (DED_CH)
    ) u_decode (
        .mode  (mode_q),
        .shadow(shadow),
        .data_o(dec_data),
        .den_o (dec_den),
        .cen_o (dec_cen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_data_o <= '0;
            drv_en_o   <= '0;
            cmp_en_o   <= '0;
            vvalid_o   <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            vvalid_o   <= swap;
            underrun_o <= vstrobe_i && !full;
            if (swap) begin
                drv_data_o <= dec_data;
                drv_en_o   <= dec_den;
                cmp_en_o   <= dec_cen;
            end
        end
    end

    assign active_mode_o = mode_q;

endmodule

// File: rtl/vwa_checker.sv
module vwa_checker #(
    parameter int CH     = 96,
    parameter int DED_CH = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wvalid_i,
    input logic          vstrobe_i,
    input logic [CH-1:0] drv_data_o,
    input logic [CH-1:0] drv_en_o,
    input logic [CH-1:0] cmp_en_o,
    input logic          vvalid_o,
    input logic          underrun_o,
    input logic          active_mode_o
);

    a_r3_no_drive_ded: assert property (@(posedge clk) disable iff (!rst_n)
        (vvalid_o && $past(active_mode_o)) |-> (drv_en_o == '0));

    a_r3_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (vvalid_o && $past(active_mode_o)) |->
            (drv_data_o[CH-1:DED_CH] == '0 && cmp_en_o[CH-1:DED_CH] == '0));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vvalid_o |=> !vvalid_o);

    a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        vvalid_o |-> $past(vstrobe_i));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vvalid_o && underrun_o));

    a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> ($stable(drv_data_o) && $stable(drv_en_o) && $stable(cmp_en_o)));

    a_r9_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_i |=> $stable(active_mode_o));

endmodule

bind vec_word_asm vwa_checker #(
    .CH    (BIDIR_CH),
    .DED_CH(DED_CH)
) u_vwa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wvalid_i     (wvalid_i),
    .vstrobe_i    (vstrobe_i),
    .drv_data_o   (drv_data_o),
    .drv_en_o     (drv_en_o),
    .cmp_en_o     (cmp_en_o),
    .vvalid_o     (vvalid_o),
    .underrun_o   (underrun_o),
    .active_mode_o(active_mode_o)
);

// File: tb/vec_word_asm_bench.sv
`timescale 1ns/1ps
module vec_word_asm_bench;

    typedef struct packed {
        logic        under;
        logic [95:0] d;
        logic [95:0] e;
        logic [95:0] c;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic        wvalid = 1'b0;
    logic [71:0] wdata = '0;
    logic        vstrobe = 1'b0;
    logic [95:0] drv_data, drv_en, cmp_en;
    logic        vvalid, underrun, active_mode;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];
    string q_tag[$];
    exp_t last_exp = '0;

    always #4 clk = ~clk;

    vec_word_asm u_vec_word_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel_i   (mode_sel),
        .wvalid_i     (wvalid),
        .wdata_i      (wdata),
        .vstrobe_i    (vstrobe),
        .drv_data_o   (drv_data),
        .drv_en_o     (drv_en),
        .cmp_en_o     (cmp_en),
        .vvalid_o     (vvalid),
        .underrun_o   (underrun),
        .active_mode_o(active_mode)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] rw();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[71:0];
    endfunction

    // expected outputs computed from R2/R3 field rules
    function automatic exp_t expect_vec(input bit ded, input logic [287:0] b);
        exp_t x;
        x = '0;
        for (int n = 0; n < 96; n++) begin
            if (!ded) begin
                x.d[n] = b[3*n];
                x.e[n] = b[3*n+1];
                x.c[n] = b[3*n+2];
            end else if (n < 64) begin
                x.d[n] = b[2*n];
                x.c[n] = ~b[2*n+1];
            end
        end
        return x;
    endfunction

    task automatic push_vec(input exp_t x, input string tag);
        q.push_back(x);
        q_tag.push_back(tag);
        last_exp = x;
    endtask

    task automatic push_under(input string tag);
        exp_t x;
        x = last_exp;
        x.under = 1'b1;
        q.push_back(x);
        q_tag.push_back(tag);
    endtask

    task automatic word(input logic [71:0] w);
        @(negedge clk);
        wvalid = 1'b1;
        wdata  = w;
    endtask

    task automatic fire(input bit with_w, input logic [71:0] w);
        @(negedge clk);
        vstrobe = 1'b1;
        wvalid  = with_w;
        wdata   = w;
        @(negedge clk);
        vstrobe = 1'b0;
        wvalid  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wvalid  = 1'b0;
            vstrobe = 1'b0;
        end
    endtask

    function automatic logic [287:0] pack4(input logic [71:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic send_vec(input bit ded, input logic [71:0] a, b, c, d, input string tag);
        logic [287:0] bits;
        bits = ded ? {144'b0, b, a} : pack4(a, b, c, d);
        push_vec(expect_vec(ded, bits), tag);
        word(a);
        word(b);
        if (!ded) begin
            word(c);
            word(d);
        end
        fire(1'b0, '0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (vvalid || underrun)) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5 unexpected pulse actual vvalid=%b underrun=%b expected none",
                             vvalid, underrun);
                end else begin
                    exp_t x;
                    string t;
                    x = q.pop_front();
                    t = q_tag.pop_front();
                    if (underrun !== x.under || vvalid !== !x.under) begin
                        n_fail++;
                        $display("FAIL %s pulse actual vv=%b ur=%b expected vv=%b ur=%b",
                                 t, vvalid, underrun, !x.under, x.under);
                    end
                    chk({t, " data"}, drv_data, x.d);
                    chk({t, " drive_en"}, drv_en, x.e);
                    chk({t, " cmp_en"}, cmp_en, x.c);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [71:0] a, b, c, d, pad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 data", drv_data, '0);
        chk("R1 drive_en", drv_en, '0);
        chk("R1 cmp_en", cmp_en, '0);
        chk("R1 pulses", {94'b0, vvalid, underrun}, '0);
        chk("R1 mode", {95'b0, active_mode}, '0);
        rst_n = 1'b1;
        idle(2);

        // R2 bidirectional vectors
        send_vec(1'b0, '1, '1, '1, '1, "R2 ones");
        send_vec(1'b0, {24{3'b101}}, {24{3'b010}}, {24{3'b110}}, {24{3'b001}}, "R2 pattern");
        for (int i = 0; i < 3; i++) begin
            send_vec(1'b0, rw(), rw(), rw(), rw(), "R2 random");
        end
        // R5 back-to-back vectors
        send_vec(1'b0, rw(), rw(), rw(), rw(), "R5 swap");

        // R7 extra word while full is dropped
        a = rw(); b = rw(); c = rw(); d = rw();
        push_vec(expect_vec(1'b0, pack4(a, b, c, d)), "R7 extra word");
        word(a); word(b); word(c); word(d); word(rw());
        fire(1'b0, '0);

        // R9 mode request while words flow is refused
        a = rw(); b = rw(); c = rw(); d = rw();
        @(negedge clk); wvalid = 1'b1; wdata = a; mode_sel = 1'b1;
        @(negedge clk); wdata = b; mode_sel = 1'b0;
        chk("R9 busy mode", {95'b0, active_mode}, '0);
        push_vec(expect_vec(1'b0, pack4(a, b, c, d)), "R9 busy vector");
        word(c); word(d);
        fire(1'b0, '0);

        // R9 / R10 accepted change discards a partial vector
        word(rw()); word(rw());
        @(negedge clk); wvalid = 1'b0; mode_sel = 1'b1;
        @(negedge clk);
        chk("R10 mode ded", {95'b0, active_mode}, 96'd1);
        send_vec(1'b1, rw(), rw(), '0, '0, "R9 flush then R3");

        // R3 dedicated patterns
        send_vec(1'b1, '1, '1, '0, '0, "R3 ones");
        send_vec(1'b1, {36{2'b01}}, {36{2'b10}}, '0, '0, "R3 pattern");

        // R4 padding bits ignored
        a = rw(); pad = rw();
        b = {16'h0000, pad[55:0]};
        send_vec(1'b1, a, b, '0, '0, "R4 pad zero");
        b = {16'hFFFF, pad[55:0]};
        send_vec(1'b1, a, b, '0, '0, "R4 pad ones");
        b = {16'hA5C3, pad[55:0]};
        send_vec(1'b1, a, b, '0, '0, "R4 pad mixed");

        // R6 underrun, partial words kept
        a = rw(); b = rw();
        word(a);
        push_under("R6 partial underrun");
        fire(1'b0, '0);
        push_vec(expect_vec(1'b1, {144'b0, b, a}), "R6 completes");
        word(b);
        fire(1'b0, '0);
        push_under("R6 empty underrun");
        fire(1'b0, '0);

        // R8 word with strobe starts next vector
        a = rw(); b = rw(); c = rw(); d = rw();
        word(a); word(b);
        push_vec(expect_vec(1'b1, {144'b0, b, a}), "R8 first");
        fire(1'b1, c);
        push_vec(expect_vec(1'b1, {144'b0, d, c}), "R8 carried word");
        word(d);
        fire(1'b0, '0);

        // R10 return to bidirectional
        @(negedge clk); wvalid = 1'b0; mode_sel = 1'b0;
        @(negedge clk);
        chk("R10 mode bidir", {95'b0, active_mode}, '0);
        send_vec(1'b0, rw(), rw(), rw(), rw(), "R2 after return");

        idle(4);
        chk("R5 queue drained", 96'(q.size()), '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule